// File: doc/BRIEF.md
# Strap-Selected Boot Source Sequencer

This block runs once after every reset. It reads a 3-bit strap word and an override code, builds an ordered list of candidate boot sources, and tries them one at a time. For each try it emits a single-cycle strobe that carries the source ID, the partition index and the byte offset of the image. It then waits for the storage or USB responder to answer with a success pulse or a failure pulse. If neither arrives within a programmable number of cycles, the try counts as a failure.

A failed try moves the sequencer to the next source. The managed-flash source is the exception: it first retries two further partitions. When a try succeeds, the winning source ID is latched and held. If every source fails, a terminal failure flag is raised. The override code can put USB, SD or SPI-NOR ahead of the strap order. A forced-USB choice is remembered across warm resets and is cleared only by a cold reset.

Source IDs used on every port: 0 none, 1 USB, 2 SPI-NOR, 3 NAND/managed flash (eMMC), 4 SD, 5 SPI-NAND.

Top module: `boot_seq_top`

## Requirements
- R1: The strap word selects the try order: 000 and 100 give USB, SPI-NOR, eMMC, SD. 001 and 101 give USB, eMMC, SD. 010 and 110 give SPI-NOR, eMMC, SD, USB. 011 gives SPI-NAND, eMMC, USB. 111 gives eMMC, SD, USB.
- R2: Empty table slots produce no try. When the list is exhausted, all_failed rises and stays high, and no further try_stb is issued.
- R3: Each try is a try_stb pulse exactly one cycle wide, with try_src set to the source. try_offset is 512 for SD, eMMC and SPI-NOR and 0 for USB and SPI-NAND.
- R4: A try that receives neither rsp_ok nor rsp_fail within tmo_limit cycles counts as failed, and the next try follows.
- R5: A failed eMMC try is repeated with try_part 1 (first boot partition) and then try_part 2 (second boot partition) before the next source. try_part is 0 for every other try.
- R6: rsp_ok during a pending try raises boot_ok with boot_src equal to the tried source. Both are held until reset, and boot_ok and all_failed are never high together.
- R7: ovr_code 01 forces USB first, 10 forces SD first and 11 forces SPI-NOR first. 00 forces nothing. After a forced source fails, the strap order follows, and the forced source is not tried a second time.
- R8: Once USB has been forced first, every later warm reset again starts with USB, whatever ovr_code says. A cold reset clears this memory.
- R9: While either reset is low, try_stb, boot_ok and all_failed are 0. After reset is released, the first try starts without any other input.
- R10: rsp_ok and rsp_fail are ignored when no try is pending: after boot_ok or all_failed has risen, they change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Power-on reset, active low, synchronous; clears everything |
| warm_rst_n | input | 1 | Warm reset, active low, synchronous; keeps the forced-USB memory |
| strap | input | 3 | Strap word selecting the try order |
| ovr_code | input | 2 | Forced-first source code, sampled after reset |
| tmo_limit | input | TMO_W (16) | Cycles to wait for a response before declaring failure |
| rsp_ok | input | 1 | Responder reports a valid image |
| rsp_fail | input | 1 | Responder reports no answer or no valid image |
| try_stb | output | 1 | One-cycle strobe starting a try |
| try_src | output | 3 | Source ID of the current try |
| try_part | output | PART_W (2) | Partition index of the current try |
| try_offset | output | OFS_W (16) | Byte offset of the image for the current try |
| boot_ok | output | 1 | Held high after a successful try |
| boot_src | output | 3 | Winning source ID, held with boot_ok |
| all_failed | output | 1 | Held high once every listed source has failed |

## Verification
A wrong list pointer or a mis-decoded strap row shows up on the very next try_stb as the wrong try_src. A partition counter that is not cleared or not advanced shows up as a wrong try_part within three tries of any eMMC attempt. A lost forced-USB memory is exposed by the first strobe after a warm reset. A stuck wait state appears as a missing strobe once tmo_limit cycles have passed. The bench predicts the full try sequence and the final flag for each strap, override and response script, and compares every strobe as it occurs.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

   typedef enum logic [2:0] {
      SRC_NONE  = 3'd0,
      SRC_USB   = 3'd1,
      SRC_SNOR  = 3'd2,
      SRC_EMMC  = 3'd3,
      SRC_SD    = 3'd4,
      SRC_SNAND = 3'd5
   } src_e;

   typedef enum logic [2:0] {
      ST_START,
      ST_SEEK,
      ST_ISSUE,
      ST_WAIT,
      ST_DONE,
      ST_EXHAUST
   } st_e;

   localparam int ORDER_SLOTS = 4;
   localparam int SRC_W       = 3;

   // one row of the strap-selected order; empty slots carry SRC_NONE
   function automatic src_e order_slot(input logic [2:0] s, input logic [1:0] k);
      src_e row [ORDER_SLOTS];
      case (s)
         3'b000, 3'b100: row = '{SRC_USB,   SRC_SNOR, SRC_EMMC, SRC_SD};
         3'b001, 3'b101: row = '{SRC_USB,   SRC_EMMC, SRC_SD,   SRC_NONE};
         3'b010, 3'b110: row = '{SRC_SNOR,  SRC_EMMC, SRC_SD,   SRC_USB};
         3'b011:         row = '{SRC_SNAND, SRC_EMMC, SRC_USB,  SRC_NONE};
         default:        row = '{SRC_EMMC,  SRC_SD,   SRC_USB,  SRC_NONE};
      endcase
      return row[k];
   endfunction

   function automatic src_e ovr_decode(input logic [1:0] c);
      case (c)
         2'b01:   return SRC_USB;
         2'b10:   return SRC_SD;
         2'b11:   return SRC_SNOR;
         default: return SRC_NONE;
      endcase
   endfunction

   function automatic logic wants_offset(input src_e s);
      return (s == SRC_SNOR) || (s == SRC_EMMC) || (s == SRC_SD);
   endfunction

endpackage

// File: rtl/boot_order_table.sv
module boot_order_table
   import boot_seq_pkg::*;
#(
   parameter int SLOTS = ORDER_SLOTS
) (
   input  logic [2:0]             strap,
   output logic [SLOTS*SRC_W-1:0] order
);

   if (SLOTS != ORDER_SLOTS) begin : g_bad_slots
      $error("boot_order_table: SLOTS must equal ORDER_SLOTS");
   end

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      assign order[i*SRC_W +: SRC_W] = order_slot(strap, 2'(i));
   end

endmodule

// File: rtl/boot_force_ctl.sv
module boot_force_ctl
   import boot_seq_pkg::*;
(
   input  logic       clk,
   input  logic       cold_rst_n,
   input  logic       capture,
   input  logic [1:0] ovr_code,
   output src_e       forced
);

   logic usb_keep_q;
   src_e req_src;

   assign req_src = ovr_decode(ovr_code);
   assign forced  = usb_keep_q ? SRC_USB : req_src;

   // survives warm reset; only the power-on reset clears it
   always_ff @(posedge clk) begin
      if (!cold_rst_n)
         usb_keep_q <= 1'b0;
      else if (capture && (forced == SRC_USB))
         usb_keep_q <= 1'b1;
   end

endmodule

// File: rtl/boot_try_timer.sv
module boot_try_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         expired
);

   if (W < 1) begin : g_bad_w
      $error("boot_try_timer: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   assign expired = run && (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (run && !expired)
         cnt_q <= cnt_q + W'(1);
   end

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
   import boot_seq_pkg::*;
#(
   parameter  int TMO_W      = 16,
   parameter  int OFS_W      = 16,
   parameter  int IMG_OFFSET = 512,
   parameter  int EMMC_PARTS = 3,
   localparam int PART_W     = (EMMC_PARTS > 1) ? $clog2(EMMC_PARTS) : 1
) (
   input  logic              clk,
   input  logic              cold_rst_n,
   input  logic              warm_rst_n,
   input  logic [2:0]        strap,
   input  logic [1:0]        ovr_code,
   input  logic [TMO_W-1:0]  tmo_limit,
   input  logic              rsp_ok,
   input  logic              rsp_fail,
   output logic              try_stb,
   output logic [2:0]        try_src,
   output logic [PART_W-1:0] try_part,
   output logic [OFS_W-1:0]  try_offset,
   output logic              boot_ok,
   output logic [2:0]        boot_src,
   output logic              all_failed
);

   localparam int LIST_N = ORDER_SLOTS + 1;        // forced slot + strap slots
   localparam int IDX_W  = $clog2(LIST_N + 1);

   if (EMMC_PARTS < 1 || EMMC_PARTS > 4) begin : g_bad_parts
      $error("boot_seq_top: EMMC_PARTS must be 1..4");
   end
   if (IMG_OFFSET < 0 || IMG_OFFSET >= (2 ** OFS_W)) begin : g_bad_ofs
      $error("boot_seq_top: IMG_OFFSET does not fit OFS_W");
   end

   logic rst_all_n;
   assign rst_all_n = cold_rst_n & warm_rst_n;

   st_e               st_q;
   src_e              list_q [LIST_N];
   logic [IDX_W-1:0]  idx_q;
   src_e              cur_q;
   logic [PART_W-1:0] part_q;
   logic              ok_q;
   src_e              win_q;
   logic              fail_q;

   logic [ORDER_SLOTS*SRC_W-1:0] order_w;
   src_e forced_w;
   logic tmo_w;
   logic capture_w;
   src_e cand;
   logic at_end, skip, more_parts;

   boot_order_table #(.SLOTS(ORDER_SLOTS)) u_tab (
      .strap (strap),
      .order (order_w)
   );

   assign capture_w = (st_q == ST_START) && rst_all_n;

   boot_force_ctl u_frc (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .capture    (capture_w),
      .ovr_code   (ovr_code),
      .forced     (forced_w)
   );

   boot_try_timer #(.W(TMO_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_all_n),
      .clr     (st_q == ST_ISSUE),
      .run     (st_q == ST_WAIT),
      .limit   (tmo_limit),
      .expired (tmo_w)
   );

   // candidate at the list pointer
   always_comb begin
      cand = SRC_NONE;
      for (int i = 0; i < LIST_N; i++)
         if (idx_q == IDX_W'(i)) cand = list_q[i];
   end

   assign at_end = (idx_q == IDX_W'(LIST_N));
   assign skip   = (cand == SRC_NONE) ||
                   ((idx_q != '0) && (cand == list_q[0]));

   if (EMMC_PARTS > 1) begin : g_retry
      assign more_parts = (cur_q == SRC_EMMC) &&
                          (part_q != PART_W'(EMMC_PARTS - 1));
   end else begin : g_noretry
      assign more_parts = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_all_n) begin
         st_q   <= ST_START;
         idx_q  <= '0;
         cur_q  <= SRC_NONE;
         part_q <= '0;
         ok_q   <= 1'b0;
         win_q  <= SRC_NONE;
         fail_q <= 1'b0;
         for (int i = 0; i < LIST_N; i++) list_q[i] <= SRC_NONE;
      end else begin
         case (st_q)
            ST_START: begin
               list_q[0] <= forced_w;
               for (int i = 0; i < ORDER_SLOTS; i++)
                  list_q[i+1] <= src_e'(order_w[i*SRC_W +: SRC_W]);
               idx_q <= '0;
               st_q  <= ST_SEEK;
            end
            ST_SEEK: begin
               if (at_end) begin
                  fail_q <= 1'b1;
                  st_q   <= ST_EXHAUST;
               end else if (skip) begin
                  idx_q <= idx_q + IDX_W'(1);
               end else begin
                  cur_q  <= cand;
                  part_q <= '0;
                  st_q   <= ST_ISSUE;
               end
            end
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (rsp_ok) begin
                  ok_q  <= 1'b1;
                  win_q <= cur_q;
                  st_q  <= ST_DONE;
               end else if (rsp_fail || tmo_w) begin
                  if (more_parts) begin
                     part_q <= part_q + PART_W'(1);
                     st_q   <= ST_ISSUE;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                     st_q  <= ST_SEEK;
                  end
               end
            end
            ST_DONE:    st_q <= ST_DONE;
            ST_EXHAUST: st_q <= ST_EXHAUST;
            default:    st_q <= ST_START;
         endcase
      end
   end

   assign try_stb    = (st_q == ST_ISSUE);
   assign try_src    = cur_q;
   assign try_part   = part_q;
   assign try_offset = wants_offset(cur_q) ? OFS_W'(IMG_OFFSET) : '0;
   assign boot_ok    = ok_q;
   assign boot_src   = win_q;
   assign all_failed = fail_q;

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk
   import boot_seq_pkg::*;
#(
   parameter int PW = 2
) (
   input logic          clk,
   input logic          cold_rst_n,
   input logic          warm_rst_n,
   input logic          try_stb,
   input logic [2:0]    try_src,
   input logic [PW-1:0] try_part,
   input logic          boot_ok,
   input logic [2:0]    boot_src,
   input logic          all_failed
);

   AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
      try_stb |=> !try_stb) else $error("try strobe longer than one cycle"); // R3

   AST_STB_HAS_SRC: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
      try_stb |-> (try_src != 3'd0)) else $error("try with empty source"); // R2

   AST_PART_ONLY_EMMC: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
      (try_stb && (try_part != '0)) |-> (try_src == 3'd3)) else $error("partition retry on non-eMMC"); // R5

   AST_OK_HOLD: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
      boot_ok |=> (boot_ok && $stable(boot_src))) else $error("boot_ok not held"); // R6

   AST_OK_SRC: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
      boot_ok |-> (boot_src != 3'd0)) else $error("boot_ok without source"); // R6

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
      !(boot_ok && all_failed)) else $error("success and failure together"); // R6

   AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
      all_failed |=> all_failed) else $error("all_failed dropped"); // R2

   AST_NO_TRY_AFTER_END: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
      (boot_ok || all_failed) |-> !try_stb) else $error("try after end"); // R10

endmodule

bind boot_seq_top boot_seq_chk #(.PW(PART_W)) u_chk (
   .clk        (clk),
   .cold_rst_n (cold_rst_n),
   .warm_rst_n (warm_rst_n),
   .try_stb    (try_stb),
   .try_src    (try_src),
   .try_part   (try_part),
   .boot_ok    (boot_ok),
   .boot_src   (boot_src),
   .all_failed (all_failed)
);

// File: tb/tb_boot_seq_top.sv
module tb_boot_seq_top;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic        cold_rst_n = 1'b0;
   logic        warm_rst_n = 1'b0;
   logic [2:0]  strap      = 3'b111;
   logic [1:0]  ovr_code   = 2'b00;
   logic [15:0] tmo_limit  = 16'd20;
   logic        rsp_ok     = 1'b0;
   logic        rsp_fail   = 1'b0;
   logic        try_stb;
   logic [2:0]  try_src;
   logic [1:0]  try_part;
   logic [15:0] try_offset;
   logic        boot_ok;
   logic [2:0]  boot_src;
   logic        all_failed;

   boot_seq_top dut (
      .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
      .strap(strap), .ovr_code(ovr_code), .tmo_limit(tmo_limit),
      .rsp_ok(rsp_ok), .rsp_fail(rsp_fail),
      .try_stb(try_stb), .try_src(try_src), .try_part(try_part),
      .try_offset(try_offset), .boot_ok(boot_ok), .boot_src(boot_src),
      .all_failed(all_failed)
   );

   // response kinds in a script
   localparam int K_FAIL = 0, K_OK = 1, K_TMO = 2;

   int n_vec = 0, n_bad = 0, cycles = 0;
   int q_src[$], q_part[$], q_kind[$];
   int script[$];
   bit sticky_m = 1'b0;
   bit exp_ok;
   int exp_win;

   task automatic chk(input bit good, input string req, input string what,
                      input int act, input int exp);
      n_vec++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic void strap_list(input int s, ref int l[$]);
      l = {};
      case (s)
         0, 4:    l = {1, 2, 3, 4};
         1, 5:    l = {1, 3, 4};
         2, 6:    l = {2, 3, 4, 1};
         3:       l = {5, 3, 1};
         default: l = {3, 4, 1};
      endcase
   endfunction

   task automatic build_model(input bit cold, input int s, input int oc);
      int forced;
      int tab[$];
      int lst[$];
      if (cold) sticky_m = 1'b0;
      forced = sticky_m ? 1 : (oc == 1 ? 1 : oc == 2 ? 4 : oc == 3 ? 2 : 0);
      if (forced == 1) sticky_m = 1'b1;
      if (forced != 0) lst.push_back(forced);
      strap_list(s, tab);
      foreach (tab[i]) if (tab[i] != forced) lst.push_back(tab[i]);
      q_src = {}; q_part = {}; q_kind = {};
      exp_ok = 1'b0; exp_win = 0;
      foreach (lst[i]) begin
         int np;
         np = (lst[i] == 3) ? 3 : 1;
         for (int p = 0; p < np; p++) begin
            if (!exp_ok) begin
               int k;
               k = (script.size() > 0) ? script.pop_front() : K_FAIL;
               q_src.push_back(lst[i]); q_part.push_back(p); q_kind.push_back(k);
               if (k == K_OK) begin exp_ok = 1'b1; exp_win = lst[i]; end
            end
         end
      end
   endtask

   task automatic run_case(input bit cold, input logic [2:0] s, input logic [1:0] oc,
                           input string tag);
      int cnt, kind;
      bit ended;
      build_model(cold, int'(s), int'(oc));
      @(negedge clk);
      rsp_ok = 1'b0; rsp_fail = 1'b0;
      strap = s; ovr_code = oc;
      if (cold) cold_rst_n = 1'b0; else warm_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!try_stb && !boot_ok && !all_failed, "R9", "outputs idle in reset",
          {try_stb, boot_ok, all_failed}, 0);
      cold_rst_n = 1'b1; warm_rst_n = 1'b1;
      cnt = 0; kind = K_FAIL; ended = 1'b0;
      for (int c = 0; c < 3000 && !ended; c++) begin
         @(negedge clk);
         rsp_ok = 1'b0; rsp_fail = 1'b0;
         if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               if (kind == K_OK) rsp_ok = 1'b1; else rsp_fail = 1'b1;
            end
         end
         if (try_stb) begin
            if (q_src.size() == 0) begin
               chk(1'b0, "R2", "unexpected try src", int'(try_src), 0);
            end else begin
               int es, ep;
               es = q_src.pop_front(); ep = q_part.pop_front(); kind = q_kind.pop_front();
               chk(int'(try_src) == es, tag, "try source", int'(try_src), es);
               chk(int'(try_part) == ep, "R5", "try partition", int'(try_part), ep);
               chk(int'(try_offset) == ((es >= 2 && es <= 4) ? 512 : 0), "R3",
                   "try offset", int'(try_offset), (es >= 2 && es <= 4) ? 512 : 0);
               if (kind != K_TMO) cnt = 2;
            end
         end
         chk(!(boot_ok && all_failed), "R6", "flags exclusive", {boot_ok, all_failed}, 0);
         if (boot_ok || all_failed) ended = 1'b1;
      end
      rsp_ok = 1'b0; rsp_fail = 1'b0;
      chk(q_src.size() == 0, "R2", "tries left unissued", q_src.size(), 0);
      chk(boot_ok == exp_ok, "R6", "boot_ok", boot_ok, exp_ok);
      chk(all_failed == !exp_ok, "R2", "all_failed", all_failed, !exp_ok);
      if (exp_ok) chk(int'(boot_src) == exp_win, "R6", "boot_src", int'(boot_src), exp_win);
      // stray responses after the end
      @(negedge clk);
      if (exp_ok) rsp_fail = 1'b1; else rsp_ok = 1'b1;
      @(negedge clk);
      rsp_ok = 1'b0; rsp_fail = 1'b0;
      repeat (3) @(negedge clk);
      chk(boot_ok == exp_ok && all_failed == !exp_ok && !try_stb, "R10",
          "stray response ignored", {boot_ok, all_failed, try_stb}, {exp_ok, !exp_ok, 1'b0});
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_bad++;
         $display("FAIL R9 watchdog: actual %0d cycles expected fewer", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      // production default with eMMC retries, SD wins
      script = {K_FAIL, K_FAIL, K_FAIL, K_OK};
      run_case(1'b1, 3'b111, 2'b00, "R1");
      // SPI-NAND first, all fail
      script = {};
      run_case(1'b1, 3'b011, 2'b00, "R1");
      // timeout on USB, SPI-NOR wins
      script = {K_TMO, K_OK};
      run_case(1'b1, 3'b000, 2'b00, "R4");
      // three-source list exhausted
      script = {K_FAIL, K_TMO, K_FAIL, K_FAIL, K_FAIL};
      run_case(1'b1, 3'b001, 2'b00, "R1");
      run_case(1'b1, 3'b101, 2'b00, "R1");
      script = {K_FAIL, K_FAIL, K_FAIL, K_FAIL, K_OK};
      run_case(1'b1, 3'b100, 2'b00, "R1");
      // forced SD ahead of a list that already holds SD
      script = {K_FAIL, K_FAIL, K_OK};
      run_case(1'b1, 3'b110, 2'b10, "R7");
      // forced SPI-NOR; eMMC first boot partition wins
      script = {K_FAIL, K_FAIL, K_OK};
      run_case(1'b1, 3'b010, 2'b11, "R7");
      // forced USB, then warm reset keeps it, cold reset drops it
      script = {K_FAIL, K_OK};
      run_case(1'b1, 3'b111, 2'b01, "R7");
      script = {K_OK};
      run_case(1'b0, 3'b111, 2'b00, "R8");
      script = {K_FAIL, K_OK};
      run_case(1'b0, 3'b010, 2'b10, "R8");
      script = {K_OK};
      run_case(1'b1, 3'b111, 2'b00, "R8");
      // warm reset without any forced USB history
      script = {K_TMO, K_FAIL, K_FAIL, K_FAIL, K_OK};
      run_case(1'b0, 3'b010, 2'b00, "R4");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule